// File: doc/BRIEF.md
# Tone Detect Guard-Time Qualifier

This block sits behind a dual-tone digit detector and turns its raw "tone present" flag and 4-bit digit code into two active-low indications. The immediate detect output follows the raw flag with one register of delay. The data-valid output is debounced by programmable guard times counted in ticks of a 1 ms timebase. A tone must be held for the on-guard time before data valid asserts. A tone must be gone for the off-guard time before data valid releases. When data valid asserts, the qualified digit is latched onto an output for a status reader.

A 2-bit guard selector picks the pair of guard times. The block also handles a digit that changes directly into another digit with no silent gap. In that case the immediate output gives a brief high pulse. Data valid drops at once, and the new digit is qualified from the start of a fresh on-guard count.

Top module: `tone_guard_qualifier`

## Requirements
- R1: `det_n` is low in the cycle after `tone_raw` is sampled high, and high in the cycle after it is sampled low. No guard time applies.
- R2: With `tone_raw` held high and `tone_code` unchanged, `valid_n` falls on the clock edge of the on-guard-th `tick_1ms`, and at the same edge `digit_q` takes that code.
- R3: While valid, `valid_n` rises on the clock edge of the off-guard-th tick counted with `tone_raw` low. A dropout that ends before that tick leaves `valid_n` low.
- R4: A tone burst that lasts fewer ticks than the on-guard time never asserts `valid_n`, and it leaves `digit_q` unchanged.
- R5: The guard times in ticks are set by `guard_sel`: 2'b01 gives on 20 and off 20, 2'b10 gives on 30 and off 30, 2'b11 gives on 40 and off 20.
- R6: The reserved selector value 2'b00 behaves exactly like 2'b01.
- R7: If `tone_code` changes while `tone_raw` stays high, `det_n` goes high in the next cycle. It stays high up to and including the cycle of the next tick, then returns low.
- R8: If the code changes while valid, `valid_n` goes high in the next cycle. The new code asserts `valid_n` again after a full on-guard count measured from the change.
- R9: If the code changes while a tone is still being qualified, the on-guard count restarts from zero with the new code.
- R10: `digit_q` carries the 4-bit detector code unchanged (digit key encoding as supplied upstream), and it holds steady while `valid_n` stays low.
- R11: After a synchronous reset, `det_n` is 1, `valid_n` is 1 and `digit_q` is 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle timebase pulse, once per millisecond |
| tone_raw | input | 1 | Raw tone-present flag from the detector |
| tone_code | input | 4 | Digit code from the detector |
| guard_sel | input | 2 | Guard-time selector |
| det_n | output | 1 | Immediate tone detect, active low |
| valid_n | output | 1 | Guard-qualified data valid, active low |
| digit_q | output | 4 | Last qualified digit code |

## Verification
The bench drives tones held for exactly one tick less than the on-guard time and for exactly the on-guard time. This separates an off-by-one counter from a correct one for each selector value, including the reserved one. Dropouts of one tick less than the off-guard time and of exactly the off-guard time show whether a short gap wrongly releases data valid. Direct digit changes are applied in both states, while qualifying and while valid. These show that the on-guard count restarts and that the tick-long detect pulse appears. A short burst followed by a long wait shows that no partial count is kept.

// File: rtl/tgq_pkg.sv
// Package: shared types for the tone guard qualifier.
// Assumes a 4-bit digit code and a 2-bit guard selector.
package tgq_pkg;
    typedef logic [3:0] digit_t;

    typedef enum logic [1:0] {
        GS_RSV   = 2'b00,
        GS_SHORT = 2'b01,
        GS_MID   = 2'b10,
        GS_LONG  = 2'b11
    } guard_sel_e;
endpackage

// File: rtl/tgq_guard_lut.sv
// Module: maps the guard selector to on- and off-guard limits in ticks.
// Assumes T_SHORT, T_MID and T_LONG all fit in CW bits; the reserved code maps like GS_SHORT.
module tgq_guard_lut #(
    parameter int T_SHORT = 20,
    parameter int T_MID   = 30,
    parameter int T_LONG  = 40,
    parameter int CW      = 6
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] on_lim,
    output logic [CW-1:0] off_lim
);
    import tgq_pkg::*;

    // Decode the selector into a limit pair.
    always_comb begin
        case (guard_sel_e'(sel))
            GS_MID: begin
                on_lim  = CW'(T_MID);
                off_lim = CW'(T_MID);
            end
            GS_LONG: begin
                on_lim  = CW'(T_LONG);
                off_lim = CW'(T_SHORT);
            end
            default: begin
                on_lim  = CW'(T_SHORT);
                off_lim = CW'(T_SHORT);
            end
        endcase
    end
endmodule

// File: rtl/tgq_edge_watch.sv
// Module: drives the immediate detect output and spots direct digit changes.
// Assumes tick is a single-cycle pulse; the change pulse lasts until the next tick.
module tgq_edge_watch (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           tone,
    input  tgq_pkg::digit_t code,
    output logic           change,
    output logic           det_n
);
    logic            prev_tone;
    tgq_pkg::digit_t prev_code;
    logic            pulse;

    // A change is a code swap while the tone stays present in consecutive cycles.
    always_comb change = tone && prev_tone && (code != prev_code);

    // Track the prior sample, hold the change pulse, and register the detect output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tone <= 1'b0;
            prev_code <= '0;
            pulse     <= 1'b0;
            det_n     <= 1'b1;
        end else begin
            prev_tone <= tone;
            prev_code <= code;
            if (change)    pulse <= 1'b1;
            else if (tick) pulse <= 1'b0;
            det_n <= !tone || change || (pulse && !tick);
        end
    end
endmodule

// File: rtl/tgq_guard_fsm.sv
// Module: guard-time qualifier that counts timebase ticks and latches the qualified digit.
// Assumes the limits are at least 1 and steady while a count runs.
module tgq_guard_fsm #(
    parameter int CW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            tone,
    input  tgq_pkg::digit_t code,
    input  logic [CW-1:0]   on_lim,
    input  logic [CW-1:0]   off_lim,
    output logic            valid_n,
    output tgq_pkg::digit_t digit_q
);
    logic            valid;
    logic [CW-1:0]   cnt;
    tgq_pkg::digit_t cand;

    // Active-low view of the qualified state.
    always_comb valid_n = !valid;

    // Count on-guard ticks while qualifying and off-guard ticks while valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            cnt     <= '0;
            cand    <= '0;
            digit_q <= '0;
        end else if (!valid) begin
            if (!tone || (code != cand)) begin
                cnt  <= '0;
                cand <= code;
            end else if (tick) begin
                if (cnt == on_lim - CW'(1)) begin
                    valid   <= 1'b1;
                    digit_q <= cand;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end else begin
            if (tone) begin
                if (code != digit_q) begin
                    valid <= 1'b0;
                    cand  <= code;
                end
                cnt <= '0;
            end else if (tick) begin
                if (cnt == off_lim - CW'(1)) begin
                    valid <= 1'b0;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tone_guard_qualifier.sv
// Module: top of the tone guard qualifier.
// Combines the selector decode, the immediate detect/change logic and the guard counter.
// Assumes tick_1ms is one clock wide and tone_raw/tone_code are synchronous to clk.
module tone_guard_qualifier #(
    parameter int T_SHORT = 20,
    parameter int T_MID   = 30,
    parameter int T_LONG  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       tone_raw,
    input  logic [3:0] tone_code,
    input  logic [1:0] guard_sel,
    output logic       det_n,
    output logic       valid_n,
    output logic [3:0] digit_q
);
    localparam int TMAX = (T_LONG > T_MID) ? ((T_LONG > T_SHORT) ? T_LONG : T_SHORT)
                                           : ((T_MID > T_SHORT) ? T_MID : T_SHORT);
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] on_lim;
    logic [CW-1:0] off_lim;
    logic          change;

    tgq_guard_lut #(.T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG), .CW(CW)) lut_i (
        .sel     (guard_sel),
        .on_lim  (on_lim),
        .off_lim (off_lim)
    );

    tgq_edge_watch edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1ms),
        .tone   (tone_raw),
        .code   (tone_code),
        .change (change),
        .det_n  (det_n)
    );

    tgq_guard_fsm #(.CW(CW)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1ms),
        .tone    (tone_raw),
        .code    (tone_code),
        .on_lim  (on_lim),
        .off_lim (off_lim),
        .valid_n (valid_n),
        .digit_q (digit_q)
    );
endmodule

// File: rtl/tgq_checker.sv
// Module: assertion checker bound to tone_guard_qualifier; observes ports only.
module tgq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1ms,
    input logic       tone_raw,
    input logic [3:0] tone_code,
    input logic [1:0] guard_sel,
    input logic       det_n,
    input logic       valid_n,
    input logic [3:0] digit_q
);
    logic past_ok;

    // Marks cycles whose previous sample came after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: an absent tone leaves the detect output high next cycle
    assert_det_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !tone_raw) |=> det_n);

    // R1: a fresh tone pulls the detect output low next cycle
    assert_det_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(tone_raw)) |=> !det_n);

    // R7: a direct code change raises the detect output next cycle
    assert_change_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tone_raw && $past(tone_raw) && (tone_code != $past(tone_code))) |=> det_n);

    // R2: data valid asserts only on a tick while the tone is present
    assert_valid_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(valid_n)) |-> ($past(tick_1ms) && $past(tone_raw)));

    // R3/R8: data valid releases only on a tick or on a tone-present code change
    assert_release_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(valid_n)) |-> ($past(tick_1ms) || $past(tone_raw)));

    // R10: the qualified digit holds while data valid stays asserted
    assert_digit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !valid_n && $past(!valid_n)) |-> $stable(digit_q));
endmodule

bind tone_guard_qualifier tgq_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1ms  (tick_1ms),
    .tone_raw  (tone_raw),
    .tone_code (tone_code),
    .guard_sel (guard_sel),
    .det_n     (det_n),
    .valid_n   (valid_n),
    .digit_q   (digit_q)
);

// File: tb/tone_guard_qualifier_tb_top.sv
// Scoreboard bench: the driver pushes expected output items, a monitor pops and compares them.
module tone_guard_qualifier_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0;
    logic       tone_raw = 1'b0;
    logic [3:0] tone_code = 4'h0;
    logic [1:0] guard_sel = 2'b01;
    logic       det_n;
    logic       valid_n;
    logic [3:0] digit_q;

    typedef struct {
        string      tag;
        logic       exp_valid_n;
        logic       exp_det_n;
        logic [3:0] exp_digit;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    tone_guard_qualifier dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1ms  (tick_1ms),
        .tone_raw  (tone_raw),
        .tone_code (tone_code),
        .guard_sel (guard_sel),
        .det_n     (det_n),
        .valid_n   (valid_n),
        .digit_q   (digit_q)
    );

    task automatic expect_out(input string tag, input logic v, input logic d, input logic [3:0] dg);
        item_t it;
        it.tag = tag; it.exp_valid_n = v; it.exp_det_n = d; it.exp_digit = dg;
        sb_q.push_back(it);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (valid_n !== it.exp_valid_n || det_n !== it.exp_det_n || digit_q !== it.exp_digit) begin
                    n_errors++;
                    $display("FAIL %s: got valid_n=%b det_n=%b digit=%h exp valid_n=%b det_n=%b digit=%h",
                             it.tag, valid_n, det_n, digit_q, it.exp_valid_n, it.exp_det_n, it.exp_digit);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got running exp finished");
            summary();
        end
    end

    // Driver: stimulus and expected values.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R11 reset state", 1'b1, 1'b1, 4'h0);

        // Code 01: on 20 / off 20
        guard_sel = 2'b01;
        tone_code = 4'h5; tone_raw = 1'b1;
        @(negedge clk);
        expect_out("R1 det low at once", 1'b1, 1'b0, 4'h0);
        wait_ticks(19);
        expect_out("R2 not valid at on-1 (sel 01)", 1'b1, 1'b0, 4'h0);
        wait_ticks(1);
        expect_out("R2 R5 valid at on=20", 1'b0, 1'b0, 4'h5);

        // Short dropout then long one
        tone_raw = 1'b0;
        @(negedge clk);
        expect_out("R1 det high on absence", 1'b0, 1'b1, 4'h5);
        wait_ticks(19);
        expect_out("R3 dropout of off-1 keeps valid", 1'b0, 1'b1, 4'h5);
        tone_raw = 1'b1;
        @(negedge clk);
        wait_ticks(5);
        expect_out("R3 return keeps valid", 1'b0, 1'b0, 4'h5);
        tone_raw = 1'b0;
        wait_ticks(19);
        expect_out("R3 second dropout restarts count", 1'b0, 1'b1, 4'h5);
        wait_ticks(1);
        expect_out("R3 R5 release at off=20", 1'b1, 1'b1, 4'h5);

        // Code change while valid
        tone_code = 4'h9; tone_raw = 1'b1;
        @(negedge clk);
        wait_ticks(20);
        expect_out("R10 digit 9 qualified", 1'b0, 1'b0, 4'h9);
        tone_code = 4'hB;
        @(negedge clk);
        expect_out("R7 R8 change pulse and release", 1'b1, 1'b1, 4'h9);
        wait_ticks(1);
        expect_out("R7 pulse ends after one tick", 1'b1, 1'b0, 4'h9);
        wait_ticks(18);
        expect_out("R8 new digit not yet valid", 1'b1, 1'b0, 4'h9);
        wait_ticks(1);
        expect_out("R8 new digit valid after full count", 1'b0, 1'b0, 4'hB);
        tone_raw = 1'b0;
        wait_ticks(20);
        expect_out("R3 release before sel 10", 1'b1, 1'b1, 4'hB);

        // Code 10: on 30 / off 30, change while qualifying
        guard_sel = 2'b10;
        tone_code = 4'h3; tone_raw = 1'b1;
        @(negedge clk);
        wait_ticks(15);
        tone_code = 4'h4;
        @(negedge clk);
        expect_out("R7 pulse while qualifying", 1'b1, 1'b1, 4'hB);
        wait_ticks(29);
        expect_out("R9 restarted count not done", 1'b1, 1'b0, 4'hB);
        wait_ticks(1);
        expect_out("R9 R5 valid at on=30", 1'b0, 1'b0, 4'h4);
        tone_raw = 1'b0;
        wait_ticks(29);
        expect_out("R5 sel 10 off-1 keeps valid", 1'b0, 1'b1, 4'h4);
        wait_ticks(1);
        expect_out("R5 sel 10 release at off=30", 1'b1, 1'b1, 4'h4);

        // Code 11: on 40 / off 20
        guard_sel = 2'b11;
        tone_code = 4'hA; tone_raw = 1'b1;
        @(negedge clk);
        wait_ticks(39);
        expect_out("R5 sel 11 on-1 not valid", 1'b1, 1'b0, 4'h4);
        wait_ticks(1);
        expect_out("R5 sel 11 valid at on=40", 1'b0, 1'b0, 4'hA);
        tone_raw = 1'b0;
        wait_ticks(19);
        expect_out("R5 sel 11 off-1 keeps valid", 1'b0, 1'b1, 4'hA);
        wait_ticks(1);
        expect_out("R5 sel 11 release at off=20", 1'b1, 1'b1, 4'hA);

        // Code 00 behaves as 01
        guard_sel = 2'b00;
        tone_code = 4'hD; tone_raw = 1'b1;
        @(negedge clk);
        wait_ticks(19);
        expect_out("R6 reserved on-1 not valid", 1'b1, 1'b0, 4'hA);
        wait_ticks(1);
        expect_out("R6 reserved valid at 20", 1'b0, 1'b0, 4'hD);
        tone_raw = 1'b0;
        wait_ticks(19);
        expect_out("R6 reserved off-1 keeps valid", 1'b0, 1'b1, 4'hD);
        wait_ticks(1);
        expect_out("R6 reserved release at 20", 1'b1, 1'b1, 4'hD);

        // Short burst never qualifies
        guard_sel = 2'b01;
        tone_code = 4'h7; tone_raw = 1'b1;
        @(negedge clk);
        wait_ticks(19);
        tone_raw = 1'b0;
        @(negedge clk);
        expect_out("R4 burst of on-1 not valid", 1'b1, 1'b1, 4'hD);
        wait_ticks(25);
        expect_out("R4 burst leaves digit unchanged", 1'b1, 1'b1, 4'hD);
        tone_raw = 1'b1;
        @(negedge clk);
        wait_ticks(19);
        expect_out("R4 no partial count kept", 1'b1, 1'b0, 4'hD);
        wait_ticks(1);
        expect_out("R10 code passed through", 1'b0, 1'b0, 4'h7);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule